// File: doc/BRIEF.md
# Video Controller Host Port with Frame Interrupt

This block is the processor-facing side of a tile-based video display controller. The CPU reaches it through two byte-wide ports picked by a single select bit. The control port collects two successive byte writes. The second byte decides whether the pair loads a VRAM access address or writes one of the mode registers. The data port moves bytes to and from VRAM at an address that steps by one after every access. A read on the control port returns the status byte, which carries the frame flag.

The timing generator delivers a one-cycle pulse at the end of the last active display line. That pulse sets a sticky frame flag. The flag drives an active-low interrupt line, gated by an enable bit in mode register 1. Reading status clears the flag. The same read also forces the two-write control sequence back to its first byte, so a status read in the middle of an address setup corrupts that setup. VRAM is outside the block and is reached through a synchronous single-port RAM interface: read data is returned one cycle after the request.

Top module: `vdc_host_port`

## Requirements
- R1: An access is a single clock cycle with `cs_n` low and either `rd_n` or `wr_n` low. `port_sel`=1 selects the control/status port and `port_sel`=0 selects the data port. On the control port, the first write is held. On the second write, bit 7 = 1 writes the held byte into mode register `wdata[2:0]`. When bit 7 is 0, the second write instead loads the 14-bit address {second[5:0], first}, and bit 6 chooses write mode (1) or read mode (0).
- R2: Mode register n appears on `mode_regs[8n+7:8n]` from the cycle after the second write.
- R3: Every status read returns the control port to its first-byte state, so the next control write is taken as a first byte.
- R4: A `frame_end` pulse sets the frame flag in the following cycle. A status read returns the flag in bit 7 with bits 6:0 zero, and the value returned is the one held before the read.
- R5: A status read clears the frame flag from the next cycle on, and reset clears it.
- R6: `irq_n` is low exactly when bit 5 of mode register 1 is 1 and the frame flag is 1. Clearing bit 5 releases `irq_n` but keeps the flag pending.
- R7: Setting bit 5 of mode register 1 while the flag is already 1 drives `irq_n` low in the cycle after the register write.
- R8: Several `frame_end` pulses with no status read between them leave a single pending flag, which one status read clears.
- R9: A data-port write stores `wdata` at the current address, with `vram_en` and `vram_we` high in that cycle. The address then steps by one and wraps from 0x3FFF to 0x0000.
- R10: Loading an address in read mode fetches that VRAM byte into a read-ahead buffer. A data-port read returns the buffer and fetches the next byte. Accesses must be at least one idle cycle apart.
- R11: If a `frame_end` pulse and a status read occur in the same cycle, the read returns the old flag and the flag is 1 afterwards.
- R12: After reset all mode registers are 0, `irq_n` is 1, no VRAM access is issued, and the control port expects a first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| port_sel | input | 1 | 1 = control/status port, 0 = data port |
| wdata | input | 8 | CPU write data |
| rdata | output | 8 | CPU read data, valid during the read cycle |
| frame_end | input | 1 | One-cycle end-of-active-display pulse |
| irq_n | output | 1 | Frame interrupt, active low |
| mode_regs | output | 64 | All eight mode registers, register n at bits 8n+7:8n |
| vram_en | output | 1 | VRAM access request |
| vram_we | output | 1 | VRAM write enable |
| vram_addr | output | 14 | VRAM address |
| vram_wdata | output | 8 | VRAM write data |
| vram_rdata | input | 8 | VRAM read data, one cycle after the request |

## Verification
- **Phase latch errors.** A wrong phase bit shows at the ports within two control writes. Either a mode register takes an unexpected value, or a later data access lands at an address other than the one loaded. The bench detects this with a write then read-back across a status read placed mid-sequence.
- **Frame flag errors.** A flag that is stuck, cleared too early, or lost on a collision shows on `irq_n` in the very next cycle when the enable is set. It also shows in bit 7 of the next status read.
- **Address counter or read-ahead errors.** These appear as a wrong `vram_addr` in the access cycle, or as a stale byte one read later.

// File: rtl/vdc_host_pkg.sv
package vdc_host_pkg;
  localparam int DATA_W     = 8;
  localparam int ADDR_W     = 14;
  localparam int NUM_REGS   = 8;
  localparam int IE_REG     = 1;
  localparam int IE_BIT     = 5;
  localparam int STAT_F_BIT = 7;

  typedef logic [DATA_W-1:0] hbyte_t;
  typedef logic [ADDR_W-1:0] vaddr_t;

  typedef struct packed {
    logic ctrl_wr;
    logic data_wr;
    logic stat_rd;
    logic data_rd;
  } host_acc_t;
endpackage

// File: rtl/vdc_ctrl_latch.sv
module vdc_ctrl_latch #(
  parameter int DW   = 8,
  parameter int AW   = 14,
  parameter int NREG = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr,
  input  logic             status_rd,
  input  logic [DW-1:0]    wdata,
  output logic             addr_load,
  output logic [AW-1:0]    addr_val,
  output logic             wr_mode_val,
  output logic [NREG*DW-1:0] regs_flat
);
  localparam int IDX_W = $clog2(NREG);
  localparam int HI_W  = AW - DW;

  logic            phase_q, phase_d;
  logic [DW-1:0]   latch_q, latch_d;
  logic            latch_en;
  logic            reg_we;
  logic [IDX_W-1:0] reg_idx;
  logic [DW-1:0]   reg_q [NREG];

  always_comb begin
    phase_d  = phase_q;
    latch_en = 1'b0;
    latch_d  = latch_q;
    if (status_rd) begin
      phase_d = 1'b0;
    end else if (ctrl_wr) begin
      phase_d = ~phase_q;
      if (!phase_q) begin
        latch_en = 1'b1;
        latch_d  = wdata;
      end
    end
  end

  always_comb begin
    reg_idx     = wdata[IDX_W-1:0];
    reg_we      = ctrl_wr & ~status_rd & phase_q & wdata[DW-1];
    addr_load   = ctrl_wr & ~status_rd & phase_q & ~wdata[DW-1];
    addr_val    = {wdata[HI_W-1:0], latch_q};
    wr_mode_val = wdata[DW-2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
    end else if (latch_en) begin
      latch_q <= latch_d;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        reg_q[g] <= '0;
      end else if (reg_we && (reg_idx == IDX_W'(g))) begin
        reg_q[g] <= latch_q;
      end
    end
    assign regs_flat[g*DW +: DW] = reg_q[g];
  end

  AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    status_rd |=> !phase_q); // R3
  AST_REG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> reg_q[$past(reg_idx)] == $past(latch_q)); // R2
  AST_SECOND_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !status_rd && phase_q) |=> !phase_q); // R1
endmodule

// File: rtl/vdc_frame_irq.sv
module vdc_frame_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_end,
  input  logic status_rd,
  input  logic irq_en,
  output logic flag,
  output logic irq_n
);
  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (status_rd) flag_d = 1'b0;
    if (frame_end) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign flag  = flag_q;
  assign irq_n = ~(irq_en & flag_q);

  AST_F_SET: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> flag_q); // R4
  AST_F_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !frame_end) |=> !flag_q); // R5
  AST_F_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!status_rd && !frame_end) |=> $stable(flag_q)); // R8
  AST_F_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && frame_end) |=> flag_q); // R11
endmodule

// File: rtl/vdc_vram_port.sv
module vdc_vram_port #(
  parameter int DW = 8,
  parameter int AW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          data_wr,
  input  logic          data_rd,
  input  logic          addr_load,
  input  logic [AW-1:0] addr_val,
  input  logic          wr_mode_val,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] vram_rdata,
  output logic          vram_en,
  output logic          vram_we,
  output logic [AW-1:0] vram_addr,
  output logic [DW-1:0] vram_wdata,
  output logic [DW-1:0] rbuf
);
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] rbuf_q, rbuf_d;
  logic          fill_q, fill_d;
  logic          prefetch;

  always_comb begin
    prefetch   = addr_load & ~wr_mode_val;
    vram_en    = data_wr | data_rd | prefetch;
    vram_we    = data_wr;
    vram_addr  = addr_load ? addr_val : addr_q;
    vram_wdata = wdata;
  end

  always_comb begin
    addr_d = addr_q;
    if (addr_load) begin
      addr_d = wr_mode_val ? addr_val : addr_val + 1'b1;
    end else if (data_wr || data_rd) begin
      addr_d = addr_q + 1'b1;
    end
    fill_d = prefetch | data_rd;
    rbuf_d = fill_q ? vram_rdata : rbuf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      fill_q <= 1'b0;
    end else begin
      addr_q <= addr_d;
      fill_q <= fill_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbuf_q <= '0;
    end else if (fill_q) begin
      rbuf_q <= rbuf_d;
    end
  end

  assign rbuf = rbuf_q;

  AST_WE_HAS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    vram_we |-> vram_en); // R9
  AST_BUF_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (vram_en && !vram_we) |=> ##1 (rbuf_q == $past(vram_rdata))); // R10
endmodule

// File: rtl/vdc_host_port.sv
module vdc_host_port
  import vdc_host_pkg::*;
#(
  parameter int DW   = DATA_W,
  parameter int AW   = ADDR_W,
  parameter int NREG = NUM_REGS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               rd_n,
  input  logic               wr_n,
  input  logic               port_sel,
  input  logic [DW-1:0]      wdata,
  output logic [DW-1:0]      rdata,
  input  logic               frame_end,
  output logic               irq_n,
  output logic [NREG*DW-1:0] mode_regs,
  output logic               vram_en,
  output logic               vram_we,
  output logic [AW-1:0]      vram_addr,
  output logic [DW-1:0]      vram_wdata,
  input  logic [DW-1:0]      vram_rdata
);
  localparam int IE_POS = IE_REG * DW + IE_BIT;

  host_acc_t     acc;
  logic          addr_load;
  logic [AW-1:0] addr_val;
  logic          wr_mode_val;
  logic          flag;
  logic          irq_en;
  logic [DW-1:0] rbuf;
  logic [DW-1:0] stat_byte;

  always_comb begin
    acc.stat_rd = ~cs_n & ~rd_n & port_sel;
    acc.data_rd = ~cs_n & ~rd_n & ~port_sel;
    acc.ctrl_wr = ~cs_n & rd_n & ~wr_n & port_sel;
    acc.data_wr = ~cs_n & rd_n & ~wr_n & ~port_sel;
  end

  vdc_ctrl_latch #(.DW(DW), .AW(AW), .NREG(NREG)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr    (acc.ctrl_wr),
    .status_rd  (acc.stat_rd),
    .wdata      (wdata),
    .addr_load  (addr_load),
    .addr_val   (addr_val),
    .wr_mode_val(wr_mode_val),
    .regs_flat  (mode_regs)
  );

  assign irq_en = mode_regs[IE_POS];

  vdc_frame_irq u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_end(frame_end),
    .status_rd(acc.stat_rd),
    .irq_en   (irq_en),
    .flag     (flag),
    .irq_n    (irq_n)
  );

  vdc_vram_port #(.DW(DW), .AW(AW)) u_vram (
    .clk        (clk),
    .rst_n      (rst_n),
    .data_wr    (acc.data_wr),
    .data_rd    (acc.data_rd),
    .addr_load  (addr_load),
    .addr_val   (addr_val),
    .wr_mode_val(wr_mode_val),
    .wdata      (wdata),
    .vram_rdata (vram_rdata),
    .vram_en    (vram_en),
    .vram_we    (vram_we),
    .vram_addr  (vram_addr),
    .vram_wdata (vram_wdata),
    .rbuf       (rbuf)
  );

  always_comb begin
    stat_byte             = '0;
    stat_byte[STAT_F_BIT] = flag;
    if (acc.stat_rd)      rdata = stat_byte;
    else if (acc.data_rd) rdata = rbuf;
    else                  rdata = '0;
  end

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> irq_n); // R6
  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({acc.ctrl_wr, acc.data_wr, acc.stat_rd, acc.data_rd}) <= 1); // R1
endmodule

// File: tb/vdc_host_port_test.sv
module vdc_host_port_test;
  localparam int OP_CW = 0, OP_DW = 1, OP_DR = 2, OP_SR = 3;
  localparam int OP_FE = 4, OP_IQ = 5, OP_RG = 6;
  localparam int FRAME_PERIOD = 40;
  localparam int NV = 44;

  // {op, data, expected}
  localparam logic [18:0] VEC [NV] = '{
    {3'd3, 8'h00, 8'h00},  // R4 status after reset
    {3'd5, 8'h00, 8'h01},  // R12 irq idle
    {3'd4, 8'h00, 8'h00},
    {3'd5, 8'h00, 8'h01},  // R6 masked
    {3'd0, 8'h20, 8'h00},
    {3'd0, 8'h81, 8'h00},
    {3'd6, 8'h01, 8'h20},  // R2
    {3'd5, 8'h00, 8'h00},  // R7 late enable
    {3'd3, 8'h00, 8'h80},  // R4
    {3'd5, 8'h00, 8'h01},  // R5
    {3'd3, 8'h00, 8'h00},  // R5
    {3'd4, 8'h00, 8'h00},
    {3'd4, 8'h00, 8'h00},
    {3'd5, 8'h00, 8'h00},
    {3'd3, 8'h00, 8'h80},  // R8
    {3'd3, 8'h00, 8'h00},  // R8 collapsed
    {3'd0, 8'h10, 8'h00},
    {3'd0, 8'h40, 8'h00},
    {3'd1, 8'hAA, 8'h00},
    {3'd1, 8'hBB, 8'h00},
    {3'd0, 8'h10, 8'h00},
    {3'd0, 8'h00, 8'h00},
    {3'd2, 8'h00, 8'hAA},  // R10
    {3'd2, 8'h00, 8'hBB},  // R10
    {3'd0, 8'h34, 8'h00},
    {3'd3, 8'h00, 8'h00},
    {3'd0, 8'h12, 8'h00},
    {3'd0, 8'h40, 8'h00},
    {3'd1, 8'hCC, 8'h00},
    {3'd0, 8'h12, 8'h00},
    {3'd0, 8'h00, 8'h00},
    {3'd2, 8'h00, 8'hCC},  // R3
    {3'd0, 8'h5A, 8'h00},
    {3'd0, 8'h87, 8'h00},
    {3'd6, 8'h07, 8'h5A},  // R1
    {3'd4, 8'h00, 8'h00},
    {3'd0, 8'h00, 8'h00},
    {3'd0, 8'h81, 8'h00},
    {3'd5, 8'h00, 8'h01},  // R6 flag kept
    {3'd0, 8'h20, 8'h00},
    {3'd0, 8'h81, 8'h00},
    {3'd5, 8'h00, 8'h00},  // R7
    {3'd3, 8'h00, 8'h80},  // R6
    {3'd5, 8'h00, 8'h01}
  };

  logic        clk;
  logic        rst_n;
  logic        cs_n, rd_n, wr_n, port_sel;
  logic [7:0]  wdata;
  logic [7:0]  rdata;
  logic        frame_end;
  logic        irq_n;
  logic [63:0] mode_regs;
  logic        vram_en, vram_we;
  logic [13:0] vram_addr;
  logic [7:0]  vram_wdata;
  logic [7:0]  vram_rdata;
  logic [7:0]  mem [256];

  int n_chk;
  int n_bad;
  bit done;

  vdc_host_port uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .port_sel(port_sel), .wdata(wdata), .rdata(rdata),
    .frame_end(frame_end), .irq_n(irq_n), .mode_regs(mode_regs),
    .vram_en(vram_en), .vram_we(vram_we), .vram_addr(vram_addr),
    .vram_wdata(vram_wdata), .vram_rdata(vram_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (vram_en) begin
      if (vram_we) mem[vram_addr[7:0]] <= vram_wdata;
      vram_rdata <= mem[vram_addr[7:0]];
    end
  end

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic idle_bus();
    cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; port_sel = 1'b0;
    wdata = 8'h00; frame_end = 1'b0;
  endtask

  // one access cycle followed by one idle cycle
  task automatic do_op(input int op, input logic [7:0] d,
                       output logic [7:0] rd_v, output logic [13:0] a_v,
                       output logic we_v);
    @(negedge clk);
    case (op)
      OP_CW: begin cs_n = 0; wr_n = 0; port_sel = 1; wdata = d; end
      OP_DW: begin cs_n = 0; wr_n = 0; port_sel = 0; wdata = d; end
      OP_DR: begin cs_n = 0; rd_n = 0; port_sel = 0; end
      OP_SR: begin cs_n = 0; rd_n = 0; port_sel = 1; end
      OP_FE: frame_end = 1'b1;
      default: ;
    endcase
    #2;
    rd_v = rdata; a_v = vram_addr; we_v = vram_we;
    @(negedge clk);
    idle_bus();
  endtask

  initial begin
    logic [7:0]  r;
    logic [13:0] a;
    logic        w;
    int          services;
    bit          svc;
    n_chk = 0; n_bad = 0; done = 0;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'hA5;
    vram_rdata = 8'h00;
    idle_bus();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R12 reset state
    #2;
    check("R12 irq_n", 16'(irq_n), 16'h1);
    check("R12 mode_regs", mode_regs[15:0] | mode_regs[31:16] | mode_regs[47:32] | mode_regs[63:48], 16'h0);
    check("R12 vram_en", 16'(vram_en), 16'h0);

    // vector table
    for (int k = 0; k < NV; k++) begin
      int op;
      op = int'(VEC[k][18:16]);
      do_op(op, VEC[k][15:8], r, a, w);
      case (op)
        OP_DR, OP_SR: check($sformatf("R4/R10 vec%0d rdata", k), 16'(r), 16'(VEC[k][7:0]));
        OP_IQ: begin #2; check($sformatf("R6/R7 vec%0d irq_n", k), 16'(irq_n), 16'(VEC[k][7:0])); end
        OP_RG: check($sformatf("R2 vec%0d reg", k), 16'(mode_regs[VEC[k][10:8]*8 +: 8]), 16'(VEC[k][7:0]));
        default: ;
      endcase
    end

    // R9 write address and wrap
    do_op(OP_CW, 8'hFF, r, a, w);
    do_op(OP_CW, 8'h7F, r, a, w);
    do_op(OP_DW, 8'h11, r, a, w);
    check("R9 addr at 3FFF", 16'(a), 16'h3FFF);
    check("R9 write enable", 16'(w), 16'h1);
    do_op(OP_DW, 8'h22, r, a, w);
    check("R9 wrap to 0", 16'(a), 16'h0000);
    do_op(OP_CW, 8'hFF, r, a, w);
    do_op(OP_CW, 8'h3F, r, a, w);
    do_op(OP_DR, 8'h00, r, a, w);
    check("R9 readback 3FFF", 16'(r), 16'h0011);

    // R11 frame end and status read in the same cycle (IE still set)
    @(negedge clk);
    frame_end = 1'b1; cs_n = 1'b0; rd_n = 1'b0; port_sel = 1'b1;
    #2;
    check("R11 old flag returned", 16'(rdata), 16'h00);
    @(negedge clk);
    idle_bus();
    #2;
    check("R11 irq asserted", 16'(irq_n), 16'h0);
    do_op(OP_SR, 8'h00, r, a, w);
    check("R11 flag kept", 16'(r), 16'h80);

    // R4 free-running frame pulses serviced by status reads
    services = 0;
    svc = 1'b0;
    for (int i = 0; i < 3 * FRAME_PERIOD + 2; i++) begin
      @(negedge clk);
      idle_bus();
      frame_end = (i < 3 * FRAME_PERIOD) && (i % FRAME_PERIOD == FRAME_PERIOD - 1);
      if (svc) begin
        cs_n = 1'b0; rd_n = 1'b0; port_sel = 1'b1;
        services++;
      end
      #2;
      svc = !irq_n && !svc;
    end
    @(negedge clk);
    idle_bus();
    check("R4 periodic services", 16'(services), 16'd3);
    #2;
    check("R4 irq released", 16'(irq_n), 16'h1);

    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule